// File: doc/BRIEF.md
# Short and Long Relative Branch Unit

This block decides the control-flow outcome of the relative branch family of an 8-bit processor with a 16-bit address space. Each request carries an opcode, the four condition flags (negative, overflow, zero, carry), the two bytes that follow the opcode, and the address of the opcode byte itself. One clock later the block reports whether the opcode belongs to the relative branch family, whether the branch is taken, the instruction length, and the next program counter. For the relative subroutine call it also asks for a push and supplies the return address to push.

Every condition exists in two forms. The short form (low opcode nibble 0) carries a signed 8-bit displacement. The long form (low opcode nibble 3) carries a 16-bit displacement that reaches any address through modular wrap. Opcode 0x63 is the relative call, which always uses the long displacement. Stack writes and instruction fetch are not part of this block. It only registers the decision.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `res_hit`, `res_taken`, `res_push` are 0 and `res_len`, `res_next_pc`, `res_push_addr` are 0.
- R2: A request sampled with `req_valid` high at a rising edge produces `res_valid` high after that edge. Without a request, `res_valid` is low after the edge and all other outputs keep their values.
- R3: Opcodes with an odd high nibble are conditional. Bits [7:6] select the flag (00 negative, 01 overflow, 10 carry, 11 zero), and bit [5] is the flag value that makes the branch taken.
- R4: High nibble 0x8 (opcodes 0x80 and 0x83) is taken whatever the flags are.
- R5: A short-form branch (low nibble 0) has length 2. Its taken target is the opcode address + 2 + `disp_lo` sign-extended to 16 bits.
- R6: A long-form branch (low nibble 3) has length 3. Its taken target is the opcode address + 3 + {`disp_hi`,`disp_lo`}, with `disp_hi` as the high byte.
- R7: A recognised branch that is not taken gives a next PC equal to the opcode address + length.
- R8: Opcode 0x63 is always taken, has length 3, and targets as in R6. It drives `res_push` high with `res_push_addr` = opcode address + 2. No other opcode drives `res_push`.
- R9: Any other opcode gives `res_hit`=0, `res_taken`=0, `res_push`=0, `res_len`=0, and `res_next_pc` equal to the opcode address.
- R10: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present |
| req_op | input | 8 | Opcode byte |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| disp_lo | input | 8 | Second instruction byte (short displacement or low byte) |
| disp_hi | input | 8 | Third instruction byte (high byte of long displacement) |
| inst_pc | input | 16 | Address of the opcode byte |
| res_valid | output | 1 | Registered result is valid |
| res_hit | output | 1 | Opcode is a relative branch or call |
| res_taken | output | 1 | Control transfers to the target |
| res_len | output | 2 | Instruction length in bytes (0 when not a hit) |
| res_next_pc | output | 16 | Next program counter |
| res_push | output | 1 | Push of the return address requested |
| res_push_addr | output | 16 | Return address to push |

## Verification
The bench sweeps all 256 opcodes against all 16 flag combinations, with displacements and addresses that vary with each vector, and it targets the places where the address arithmetic wraps. A design that confused the flag-select bits with the sense bit would take the wrong branch on one half of the conditional opcodes. A design that zero-extended the short displacement would jump forward on backward branches. A design that counted the offset from the opcode address rather than from the following instruction would land 2 or 3 bytes short. Further checks aim at the call's return address (last byte of the call, not the following instruction), at near-miss opcodes such as 0x03, 0x23, 0x60 and 0xA0 that must stay inert, and at the hold behaviour when no request is present.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_SHORT = 2'd1,
    FORM_LONG  = 2'd2,
    FORM_CALL  = 2'd3
  } rbu_form_e;

  // Index into the flag vector {z, c, v, n}; value equals opcode bits [7:6]
  typedef enum logic [1:0] {
    SEL_NEG  = 2'd0,
    SEL_OVF  = 2'd1,
    SEL_CRY  = 2'd2,
    SEL_ZERO = 2'd3
  } rbu_sel_e;

  typedef struct packed {
    rbu_form_e form;
    logic      uncond;
    rbu_sel_e  sel;
    logic      sense;
  } rbu_dec_t;

  localparam logic [BYTE_W-1:0] OP_REL_CALL  = 8'h63;
  localparam logic [3:0]        NIB_ALWAYS   = 4'h8;
  localparam logic [3:0]        NIB_SHORT    = 4'h0;
  localparam logic [3:0]        NIB_LONG     = 4'h3;

  function automatic logic [1:0] f_len(input rbu_form_e form);
    case (form)
      FORM_SHORT: f_len = 2'd2;
      FORM_LONG,
      FORM_CALL:  f_len = 2'd3;
      default:    f_len = 2'd0;
    endcase
  endfunction

  function automatic logic f_is_branch_nibble(input logic [3:0] hi);
    f_is_branch_nibble = hi[0] || (hi == NIB_ALWAYS);
  endfunction

endpackage

// File: rtl/rbu_decode.sv
module rbu_decode
  import rbu_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output rbu_dec_t          dec
);
  logic [3:0] hi_nib;
  logic [3:0] lo_nib;
  logic       fam;
  logic       is_call;

  assign hi_nib  = op[7:4];
  assign lo_nib  = op[3:0];
  assign fam     = f_is_branch_nibble(hi_nib);
  assign is_call = (op == OP_REL_CALL);

  always_comb begin
    dec.form   = FORM_NONE;
    dec.uncond = 1'b0;
    dec.sel    = rbu_sel_e'(op[7:6]);
    dec.sense  = op[5];
    if (is_call) begin
      dec.form   = FORM_CALL;
      dec.uncond = 1'b1;
    end else if (fam && lo_nib == NIB_SHORT) begin
      dec.form   = FORM_SHORT;
      dec.uncond = (hi_nib == NIB_ALWAYS);
    end else if (fam && lo_nib == NIB_LONG) begin
      dec.form   = FORM_LONG;
      dec.uncond = (hi_nib == NIB_ALWAYS);
    end
  end
endmodule

// File: rtl/rbu_cond.sv
module rbu_cond
  import rbu_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 4
) (
  input  logic [NUM_FLAGS-1:0] flags,   // {zero, carry, overflow, negative}
  input  rbu_sel_e             sel,
  input  logic                 sense,
  input  logic                 uncond,
  output logic                 met
);
  logic [NUM_FLAGS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign hit_vec[i] = (int'(sel) == i) && (flags[i] == sense);
  end

  assign met = uncond || (|hit_vec);
endmodule

// File: rtl/rbu_target.sv
module rbu_target
  import rbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  rbu_form_e         form,
  input  logic [ADDR_W-1:0] pc,
  input  logic [BYTE_W-1:0] d_lo,
  input  logic [BYTE_W-1:0] d_hi,
  output logic [1:0]        len,
  output logic [ADDR_W-1:0] follow_pc,
  output logic [ADDR_W-1:0] target_pc,
  output logic [ADDR_W-1:0] ret_pc
);
  localparam int unsigned WIDE_W = 2 * BYTE_W;

  function automatic logic [ADDR_W-1:0] f_sext_short(input logic [BYTE_W-1:0] d);
    f_sext_short = {{(ADDR_W-BYTE_W){d[BYTE_W-1]}}, d};
  endfunction

  function automatic logic [ADDR_W-1:0] f_sext_wide(input logic [WIDE_W-1:0] d);
    f_sext_wide = {{(ADDR_W-WIDE_W){d[WIDE_W-1]}}, d};
  endfunction

  logic [ADDR_W-1:0] offset;

  assign len       = f_len(form);
  assign follow_pc = pc + ADDR_W'(len);
  assign ret_pc    = pc + ADDR_W'(2);

  always_comb begin
    if (form == FORM_SHORT) offset = f_sext_short(d_lo);
    else                    offset = f_sext_wide({d_hi, d_lo});
  end

  assign target_pc = follow_pc + offset;
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_op,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [7:0]        disp_lo,
  input  logic [7:0]        disp_hi,
  input  logic [ADDR_W-1:0] inst_pc,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_taken,
  output logic [1:0]        res_len,
  output logic [ADDR_W-1:0] res_next_pc,
  output logic              res_push,
  output logic [ADDR_W-1:0] res_push_addr
);
  rbu_dec_t          dec;
  logic              cond_met;
  logic [1:0]        len_c;
  logic [ADDR_W-1:0] follow_pc;
  logic [ADDR_W-1:0] target_pc;
  logic [ADDR_W-1:0] ret_pc;
  logic              hit_c;
  logic              taken_c;
  logic              push_c;
  logic [ADDR_W-1:0] next_c;

  rbu_decode u_dec (
    .op  (req_op),
    .dec (dec)
  );

  rbu_cond #(.NUM_FLAGS(4)) u_cond (
    .flags  ({flag_z, flag_c, flag_v, flag_n}),
    .sel    (dec.sel),
    .sense  (dec.sense),
    .uncond (dec.uncond),
    .met    (cond_met)
  );

  rbu_target #(.ADDR_W(ADDR_W)) u_tgt (
    .form      (dec.form),
    .pc        (inst_pc),
    .d_lo      (disp_lo),
    .d_hi      (disp_hi),
    .len       (len_c),
    .follow_pc (follow_pc),
    .target_pc (target_pc),
    .ret_pc    (ret_pc)
  );

  assign hit_c   = (dec.form != FORM_NONE);
  assign taken_c = hit_c && cond_met;
  assign push_c  = (dec.form == FORM_CALL);

  always_comb begin
    if (!hit_c)       next_c = inst_pc;
    else if (taken_c) next_c = target_pc;
    else              next_c = follow_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_taken     <= 1'b0;
      res_len       <= 2'd0;
      res_next_pc   <= '0;
      res_push      <= 1'b0;
      res_push_addr <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_hit       <= hit_c;
        res_taken     <= taken_c;
        res_len       <= len_c;
        res_next_pc   <= next_c;
        res_push      <= push_c;
        res_push_addr <= push_c ? ret_pc : '0;
      end
    end
  end
endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [7:0]        req_op,
  input logic [ADDR_W-1:0] inst_pc,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_taken,
  input logic [1:0]        res_len,
  input logic [ADDR_W-1:0] res_next_pc,
  input logic              res_push,
  input logic [ADDR_W-1:0] res_push_addr
);
  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(res_next_pc) && $stable(res_taken)));

  p_always_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 8'h80) |=> res_taken);

  p_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_len == 2'd2 || res_len == 2'd3));

  p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |=>
      ((res_hit && !res_taken) |-> res_next_pc == $past(inst_pc) + ADDR_W'(res_len)));

  p_push_call_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 8'h63) |=> !res_push);

  p_push_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (res_push |-> (res_taken && res_len == 2'd3 &&
                                 res_push_addr == $past(inst_pc) + ADDR_W'(2))));

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (!res_taken && !res_push && res_len == 2'd0));
endmodule

bind rel_branch_unit rel_branch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_op        (req_op),
  .inst_pc       (inst_pc),
  .res_valid     (res_valid),
  .res_hit       (res_hit),
  .res_taken     (res_taken),
  .res_len       (res_len),
  .res_next_pc   (res_next_pc),
  .res_push      (res_push),
  .res_push_addr (res_push_addr)
);

// File: tb/rel_branch_unit_tb.sv
`timescale 1ns/1ps
module rel_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_op = '0;
  logic        flag_n = 0, flag_v = 0, flag_z = 0, flag_c = 0;
  logic [7:0]  disp_lo = '0, disp_hi = '0;
  logic [15:0] inst_pc = '0;
  logic        res_valid, res_hit, res_taken, res_push;
  logic [1:0]  res_len;
  logic [15:0] res_next_pc, res_push_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rel_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
    .disp_lo(disp_lo), .disp_hi(disp_hi), .inst_pc(inst_pc),
    .res_valid(res_valid), .res_hit(res_hit), .res_taken(res_taken),
    .res_len(res_len), .res_next_pc(res_next_pc), .res_push(res_push),
    .res_push_addr(res_push_addr)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h (op=%02h pc=%04h)",
               req, what, got, exp, req_op, inst_pc);
    end
  endtask

  function automatic int wrap16(input int x);
    return ((x % 65536) + 65536) % 65536;
  endfunction

  task automatic run_vec(input int op, input int fl, input int pc, input int dl, input int dh,
                         input string tag_extra);
    int hi, lo, len, disp, nxt, exp_hit, exp_tk, exp_push;
    bit fam, n, v, z, c;
    string rq_len, rq_tk;
    n = fl[3]; v = fl[2]; z = fl[1]; c = fl[0];
    hi = op / 16; lo = op % 16;
    fam = (hi % 2 == 1) || (hi == 8);
    exp_hit = 0; exp_tk = 0; exp_push = 0; len = 0; disp = 0;
    rq_len = "R9"; rq_tk = "R9";
    if (op == 'h63) begin
      exp_hit = 1; exp_tk = 1; exp_push = 1; len = 3; disp = dh * 256 + dl;
      rq_len = "R8"; rq_tk = "R8";
    end else if (fam && (lo == 0 || lo == 3)) begin
      exp_hit = 1;
      if (lo == 0) begin
        len = 2; disp = (dl < 128) ? dl : dl - 256; rq_len = "R5";
      end else begin
        len = 3; disp = dh * 256 + dl; rq_len = "R6";
      end
      case (hi)
        1: exp_tk = !n;   3: exp_tk = n;
        5: exp_tk = !v;   7: exp_tk = v;
        9: exp_tk = !c;   11: exp_tk = c;
        13: exp_tk = !z;  15: exp_tk = z;
        default: exp_tk = 1;
      endcase
      rq_tk = (hi == 8) ? "R4" : "R3";
    end
    if (!exp_hit)     nxt = pc;
    else if (exp_tk)  nxt = wrap16(pc + len + disp);
    else              nxt = wrap16(pc + len);

    @(negedge clk);
    req_valid = 1; req_op = op[7:0];
    {flag_n, flag_v, flag_z, flag_c} = fl[3:0];
    disp_lo = dl[7:0]; disp_hi = dh[7:0]; inst_pc = pc[15:0];
    @(negedge clk);
    check("R2", "res_valid", int'(res_valid), 1);
    check(rq_len, "res_hit", int'(res_hit), exp_hit);
    check(rq_tk, "res_taken", int'(res_taken), exp_tk);
    check(rq_len, "res_len", int'(res_len), len);
    if (tag_extra != "")
      check(tag_extra, "res_next_pc", int'(res_next_pc), nxt);
    else
      check((exp_hit && !exp_tk) ? "R7" : rq_len, "res_next_pc", int'(res_next_pc), nxt);
    check(exp_push ? "R8" : "R8_nopush", "res_push", int'(res_push), exp_push);
    if (exp_push)
      check(tag_extra != "" ? tag_extra : "R8", "res_push_addr",
            int'(res_push_addr), wrap16(pc + 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "res_valid", int'(res_valid), 0);
    check("R1", "res_taken", int'(res_taken), 0);
    check("R1", "res_push", int'(res_push), 0);
    check("R1", "res_len", int'(res_len), 0);
    check("R1", "res_next_pc", int'(res_next_pc), 0);
    check("R1", "res_push_addr", int'(res_push_addr), 0);
    @(negedge clk);
    rst_n = 1;

    // Exhaustive opcode x flag sweep with varying addresses and displacements
    for (int op = 0; op < 256; op++) begin
      for (int fl = 0; fl < 16; fl++) begin
        run_vec(op, fl, (op * 1031 + fl * 4099 + 17) % 65536,
                (op * 37 + fl * 11) % 256, ((op * 53) ^ (fl * 29)) % 256, "");
      end
    end

    // R10: wrap-around corner cases
    run_vec('h80, 0, 'hFFFE, 'h7F, 0, "R10");     // short forward across top
    run_vec('h80, 0, 'h0001, 'h80, 0, "R10");     // short backward below zero
    run_vec('h83, 0, 'hFFF0, 'h20, 'h00, "R10");  // long forward wraps
    run_vec('h83, 0, 'h0010, 'hF0, 'hFF, "R10");  // long -16 via modular add
    run_vec('h63, 0, 'hFFFF, 'h00, 'h00, "R10");  // call: return addr wraps
    run_vec('hF0, 2, 'h0000, 'h80, 0, "R10");     // taken equal, backward from 0
    run_vec('h10, 0, 'hFFFF, 'h00, 0, "R10");     // taken plus, zero disp
    run_vec('h30, 0, 'hFFFF, 'h05, 0, "R10");     // not taken, fall-through wraps

    // R2: idle cycle holds outputs
    run_vec('h83, 0, 'h1234, 'h11, 'h22, "");
    held = res_next_pc;
    @(negedge clk);
    req_valid = 0; req_op = 8'h10; inst_pc = 16'h4444; disp_lo = 8'h01;
    @(negedge clk);
    check("R2", "res_valid idle", int'(res_valid), 0);
    check("R2", "res_next_pc held", int'(res_next_pc), int'(held));
    check("R2", "res_taken held", int'(res_taken), 1);
    @(negedge clk);
    check("R2", "res_next_pc held 2", int'(res_next_pc), int'(held));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule